// File: doc/BRIEF.md
# Line-Doubling Deinterlacer Buffer Control

This block turns a stream of interlaced field lines into progressive output by showing every source line twice. Two line stores take turns. While one collects the pixels of the line now arriving, the other is read out at the full system clock rate. It is read out two times in a row, so each stored line fills two output lines. A single clock stands for the fast output pixel clock. Incoming pixels arrive with a write enable that the source normally raises on every second cycle, which gives the half-rate input.

A one-cycle line-start pulse ends the current input line. It swaps the two stores, restarts the write position, and starts the double readout of the line that has just closed. That readout starts only if the closed line held a complete set of pixels. With the default configuration, 720 pixels per line and 24-bit pixels, the output is 720 x 480 progressive at 60 Hz.

Top module: `ldbl_deint`

## Requirements
- R1: Out of reset `out_vld` is low and `out_pix` is zero, and they stay that way until a line holding LINE_PIX pixels has been closed by a line start.
- R2: The line starts alternate the roles of the two stores. The line closed by one line start is replayed while the next line is collected in the other store. This holds whether input pixels arrive on alternate cycles or on every cycle.
- R3: Let `in_sol` be high in cycle c, closing a line of LINE_PIX stored pixels. Then `out_vld` is high from cycle c+2 for exactly 2*LINE_PIX consecutive cycles. It carries stored pixels 0 to LINE_PIX-1 in write order, then the same sequence a second time, unless another line start cuts it short.
- R4: A line that received fewer than LINE_PIX pixels before its closing line start produces no valid output at all.
- R5: Within one line, pixels written after the first LINE_PIX are discarded. The replay contains only the first LINE_PIX.
- R6: When `in_we` is high in the same cycle as `in_sol`, that pixel is pixel 0 of the new line.
- R7: A line start during a replay ends it at once. `out_vld` is low in cycle c+1, and a new replay, if any, starts in cycle c+2.
- R8: `out_pix` is zero whenever `out_vld` is low.
- R9: In no cycle is a store written and read at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output pixel clock, twice the input pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_sol | input | 1 | One-cycle pulse that closes the current input line |
| in_we | input | 1 | Input pixel valid |
| in_pix | input | PIX_W | Input pixel |
| out_vld | output | 1 | Output pixel valid |
| out_pix | output | PIX_W | Output pixel, zero when not valid |

## Verification
The hardest case to reach is a line start that arrives in the middle of a replay, while the other store is also being written, because a normal line period always gives the replay time to finish. The bench builds this case with a deliberately short line period. It writes that line on every cycle so that eight pixels still fit, and the next line start then cuts off the replay of the previous line. Partial lines, overlong lines and a pixel arriving in the same cycle as the line start are mixed into the same stream. Every output cycle is checked against a schedule that the bench computes from the line-start times.

// File: rtl/ldbl_pkg.sv
package ldbl_pkg;
  // Which of the two replays of a stored line is running.
  typedef enum logic {
    PASS_FIRST  = 1'b0,
    PASS_SECOND = 1'b1
  } pass_e;

  // Number of stores; the role-swap scheme depends on exactly two.
  localparam int NUM_STORES = 2;
endpackage

// File: rtl/ldbl_line_ram.sv
module ldbl_line_ram #(
  parameter int DW    = 24,
  parameter int DEPTH = 720,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_data_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= mem[rd_addr];
  end

  assign rd_data = rd_data_q;

  // R9: a store is never read and written in the same cycle
  p_no_same_cycle_rw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

// File: rtl/ldbl_wr_ctrl.sv
module ldbl_wr_ctrl #(
  parameter int LINE_PIX = 720,
  parameter int AW       = $clog2(LINE_PIX),
  parameter int CW       = $clog2(LINE_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sol,
  input  logic          in_we,
  output logic          wr_en,
  output logic          wr_sel,
  output logic [AW-1:0] wr_addr,
  output logic          swap,
  output logic          closed_full,
  output logic          closed_sel
);
  localparam logic [CW-1:0] FULL = CW'(LINE_PIX);

  logic          wsel_q, wsel_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic [CW-1:0] cnt_eff;
  logic          sel_eff;

  always_comb begin
    sel_eff = in_sol ? ~wsel_q : wsel_q;
    cnt_eff = in_sol ? '0 : wcnt_q;
    wr_en   = in_we && (cnt_eff < FULL);
    wr_sel  = sel_eff;
    wr_addr = cnt_eff[AW-1:0];
    wcnt_d  = wr_en ? cnt_eff + CW'(1) : cnt_eff;
    wsel_d  = sel_eff;
  end

  assign swap        = in_sol;
  assign closed_full = (wcnt_q == FULL);
  assign closed_sel  = wsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      wsel_q <= wsel_d;
      wcnt_q <= wcnt_d;
    end
  end

  // R5: the per-line pixel count never exceeds a full line
  p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= FULL);
  // R2: every line start flips the store being written
  p_swap_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_sol |=> (wsel_q != $past(wsel_q)));
  // R6: a pixel beside the line start is the first pixel of the new line
  p_sol_pixel_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sol && in_we) |=> (wcnt_q == CW'(1)));
endmodule

// File: rtl/ldbl_rd_ctrl.sv
module ldbl_rd_ctrl
  import ldbl_pkg::*;
#(
  parameter int LINE_PIX = 720,
  parameter int AW       = $clog2(LINE_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic          closed_full,
  input  logic          closed_sel,
  output logic          rd_en,
  output logic          rd_sel,
  output logic [AW-1:0] rd_addr
);
  localparam logic [AW-1:0] LAST = AW'(LINE_PIX - 1);

  logic          run_q, run_d;
  logic          rsel_q, rsel_d;
  logic [AW-1:0] raddr_q, raddr_d;
  pass_e         pass_q, pass_d;
  logic          last_addr;

  assign last_addr = (raddr_q == LAST);

  always_comb begin
    run_d   = run_q;
    rsel_d  = rsel_q;
    raddr_d = raddr_q;
    pass_d  = pass_q;
    if (swap) begin
      run_d   = closed_full;
      rsel_d  = closed_sel;
      raddr_d = '0;
      pass_d  = PASS_FIRST;
    end else if (run_q) begin
      if (last_addr) begin
        raddr_d = '0;
        if (pass_q == PASS_SECOND) run_d  = 1'b0;
        else                       pass_d = PASS_SECOND;
      end else begin
        raddr_d = raddr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      rsel_q  <= 1'b0;
      raddr_q <= '0;
      pass_q  <= PASS_FIRST;
    end else begin
      run_q   <= run_d;
      rsel_q  <= rsel_d;
      raddr_q <= raddr_d;
      pass_q  <= pass_d;
    end
  end

  // A line start stops the read of the current cycle (R7).
  assign rd_en   = run_q & ~swap;
  assign rd_sel  = rsel_q;
  assign rd_addr = raddr_q;

  // R3: closing a full line starts a replay at address zero
  p_full_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && closed_full) |=> (run_q && raddr_q == '0 && pass_q == PASS_FIRST));
  // R4: closing a short line starts nothing
  p_short_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !closed_full) |=> !run_q);
  // R3: the replay stops after the last address of the second pass
  p_two_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !swap && last_addr && pass_q == PASS_SECOND) |=> !run_q);
  // R3: read address stays inside the line
  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (raddr_q <= LAST));
endmodule

// File: rtl/ldbl_deint.sv
module ldbl_deint
  import ldbl_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter int LINE_PIX = 720
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sol,
  input  logic             in_we,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_vld,
  output logic [PIX_W-1:0] out_pix
);
  localparam int AW = $clog2(LINE_PIX);
  localparam int CW = $clog2(LINE_PIX + 1);

  logic          wr_en, wr_sel, swap, closed_full, closed_sel;
  logic [AW-1:0] wr_addr;
  logic          rd_en, rd_sel;
  logic [AW-1:0] rd_addr;
  logic [PIX_W-1:0] rdat [NUM_STORES];
  logic          vld_q, osel_q;

  ldbl_wr_ctrl #(.LINE_PIX(LINE_PIX), .AW(AW), .CW(CW)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_sol(in_sol), .in_we(in_we),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .swap(swap), .closed_full(closed_full), .closed_sel(closed_sel)
  );

  ldbl_rd_ctrl #(.LINE_PIX(LINE_PIX), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .swap(swap), .closed_full(closed_full),
    .closed_sel(closed_sel), .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr)
  );

  for (genvar b = 0; b < NUM_STORES; b++) begin : g_store
    ldbl_line_ram #(.DW(PIX_W), .DEPTH(LINE_PIX), .AW(AW)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (wr_sel == 1'(b))), .wr_addr(wr_addr), .wr_data(in_pix),
      .rd_en(rd_en && (rd_sel == 1'(b))), .rd_addr(rd_addr), .rd_data(rdat[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      osel_q <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) osel_q <= rd_sel;
    end
  end

  assign out_vld = vld_q;
  assign out_pix = vld_q ? rdat[osel_q] : '0;

  // R9: the store being written is never the one being read
  p_no_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wr_sel != rd_sel));
  // R7: a line start leaves a one-cycle gap in the output
  p_sol_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sol |=> !out_vld);
  // R3: each read issued yields a valid pixel one cycle later
  p_read_to_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> out_vld);
endmodule

// File: tb/ldbl_deint_bench.sv
module ldbl_deint_bench;
  localparam int CLK_NS = 10;
  localparam int L      = 8;
  localparam int W      = 24;
  localparam int NEXP   = 4096;

  logic         clk, rst_n, in_sol, in_we;
  logic [W-1:0] in_pix;
  logic         out_vld;
  logic [W-1:0] out_pix;

  ldbl_deint #(.PIX_W(W), .LINE_PIX(L)) u_ldbl_deint (
    .clk(clk), .rst_n(rst_n), .in_sol(in_sol), .in_we(in_we),
    .in_pix(in_pix), .out_vld(out_vld), .out_pix(out_pix)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  bit           ev [NEXP];
  logic [W-1:0] ep [NEXP];
  logic [W-1:0] line_m [L];
  int cnt_m, n, vecs, fails;
  bit done;
  string req;

  // Compare outputs with the schedule; zero pixel expected when idle (R8).
  task automatic check();
    vecs++;
    if (n >= NEXP) return;
    if (out_vld !== ev[n] || out_pix !== ep[n]) begin
      fails++;
      $display("FAIL %s cycle %0d: actual vld=%0b pix=%06h expected vld=%0b pix=%06h",
               req, n, out_vld, out_pix, ev[n], ep[n]);
    end
  endtask

  task automatic drive(input bit sol, input bit we, input logic [W-1:0] pix);
    if (sol) begin
      for (int j = n + 1; j <= n + 2*L + 2 && j < NEXP; j++) begin
        ev[j] = 1'b0; ep[j] = '0;
      end
      if (cnt_m == L)
        for (int k = 0; k < 2*L; k++)
          if (n + 2 + k < NEXP) begin
            ev[n+2+k] = 1'b1; ep[n+2+k] = line_m[k % L];
          end
      cnt_m = 0;
    end
    if (we && cnt_m < L) begin
      line_m[cnt_m] = pix; cnt_m++;
    end
    in_sol = sol; in_we = we; in_pix = pix;
    @(negedge clk);
    n++;
    check();
  endtask

  task automatic send_line(input int npix, input int seed, input bit we_sol,
                           input int period, input bit every);
    int k;
    bit we;
    k = 0;
    for (int c = 0; c < period; c++) begin
      we = 1'b0;
      if (c == 0) we = we_sol && (npix > 0);
      else if (k < npix && (every || (c % 2 == 1))) we = 1'b1;
      if (we) begin
        drive(c == 0, 1'b1, {seed[7:0], k[15:0]});
        k++;
      end else begin
        drive(c == 0, 1'b0, '0);
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NEXP; j++) begin ev[j] = 1'b0; ep[j] = '0; end
    n = 0; vecs = 0; fails = 0; cnt_m = 0; done = 1'b0;
    rst_n = 1'b0; in_sol = 1'b0; in_we = 1'b0; in_pix = '0;
    req = "R1";
    @(negedge clk);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, '0);   // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, '0);   // R1 after reset
    send_line(L, 1, 1'b0, 22, 1'b0);                     // R1: nothing closed yet
    req = "R3";
    send_line(L, 2, 1'b0, 22, 1'b0);                     // R3 replay of line 1
    req = "R2";
    send_line(L, 3, 1'b0, 22, 1'b0);
    send_line(L, 4, 1'b0, 22, 1'b0);
    req = "R5";
    send_line(L + 4, 5, 1'b0, 26, 1'b0);                 // R5 overlong line
    req = "R6";
    send_line(L, 6, 1'b1, 22, 1'b0);                     // R6 pixel with line start
    req = "R9";
    send_line(L, 7, 1'b0, 22, 1'b1);                     // R9/R2 writes every cycle
    req = "R7";
    send_line(L, 8, 1'b0, 10, 1'b1);                     // R7 short period cuts replay
    send_line(L, 9, 1'b0, 22, 1'b0);
    req = "R4";
    send_line(5, 10, 1'b0, 22, 1'b0);                    // R4 short line
    send_line(L, 11, 1'b0, 22, 1'b0);
    send_line(0, 12, 1'b0, 22, 1'b0);
    send_line(0, 13, 1'b0, 22, 1'b0);                    // R4 empty line
    req = "R8";
    for (int i = 0; i < 25; i++) drive(1'b0, 1'b0, '0);  // R8 idle output zero
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule